// File: doc/BRIEF.md
# Explicit Result Routing Network

This block moves results between five functional units (ALU, register, load/store, move and branch) without a shared register file. Every unit pushes its results into a result queue inside the block. Every unit also draws its source operands from an operand queue inside the block. The unit takes these operands in order and never names where they come from.

Producing instructions carry no destination. Where each result goes is set by a separate stream of routing commands. A command names a source unit, a destination unit and a last-use flag. The block copies the result at the head of the source unit's result queue into the tail of the destination unit's operand queue. It releases the source entry only when the flag is set. A result can therefore go to any number of consumers, one command each, and the producing side does no duplicate work.

All three kinds of edge use valid/ready handshakes: result queues in, operand queues out, and the command port. A command that cannot complete holds its ready low until it can.

Top module: `rroute_net`

## Requirements
- R1: After a synchronous active-high reset, every result queue and operand queue is empty. All `opd_valid` bits are 0, all `res_ready` bits are 1, and `route_err` is 0.
- R2: Unit indices are ALU=0, register=1, load/store=2, move=3, branch=4, for both `cmd_src` and `cmd_dst`. Any of the 25 source/destination pairs, including a unit routing to itself, delivers correctly.
- R3: When a legal command is accepted at a clock edge, the head value of the source result queue is written into the destination operand queue at that edge. The destination's `opd_valid` is high after that edge.
- R4: A command with `cmd_last`=0 leaves the source head in place, so the next command from that source delivers the same value again.
- R5: A command with `cmd_last`=1 removes the source head after copying it.
- R6: A legal command whose source result queue is empty keeps `cmd_ready` low, and nothing is delivered, until a result arrives.
- R7: Each operand queue holds 4 entries of 32 bits. A legal command whose destination operand queue is full keeps `cmd_ready` low and leaves the queue contents unchanged.
- R8: Each result queue holds 4 entries of 32 bits. `res_ready` of a unit is low while its result queue is full.
- R9: A command with `cmd_src` or `cmd_dst` in 5 to 7 is accepted at once and moves no data. `route_err` is high for exactly the one cycle after the accepting edge.
- R10: Each operand queue hands values to its unit in the order in which the commands delivered them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 5 | Per unit: a result is offered |
| res_ready | output | 5 | Per unit: result queue has space |
| res_data | input | 160 | Per unit 32-bit result, unit i in bits [32i+31:32i] |
| cmd_valid | input | 1 | Routing command offered |
| cmd_ready | output | 1 | Routing command taken this cycle |
| cmd_src | input | 3 | Source unit index |
| cmd_dst | input | 3 | Destination unit index |
| cmd_last | input | 1 | Last use of the source head; release it |
| opd_valid | output | 5 | Per unit: operand available |
| opd_ready | input | 5 | Per unit: unit takes the operand |
| opd_data | output | 160 | Per unit 32-bit operand, unit i in bits [32i+31:32i] |
| route_err | output | 1 | One-cycle pulse after an illegal command is taken |

## Verification
A routed value becomes visible on the destination operand port one edge after the command is taken. It leaves the queue one edge after the consumer's ready meets its valid. `route_err` rises one edge after an illegal command is taken and falls on the next edge.

The bench drives its inputs just after a rising edge and samples on the falling edge. It records the expected value for a destination on the falling edge where it sees `cmd_ready` high. On the next falling edge it checks `opd_valid` of that destination, or `route_err` for an illegal command. A scoreboard monitor compares every operand that is actually consumed against the per-destination expected queue.

// File: rtl/rroute_pkg.sv
package rroute_pkg;

    localparam int NUNITS = 5;
    localparam int UNIT_W = 3;
    localparam int DATA_W = 32;
    localparam int QDEPTH = 4;

    typedef enum logic [UNIT_W-1:0] {
        U_ALU    = 3'd0,
        U_REG    = 3'd1,
        U_LDST   = 3'd2,
        U_MOVE   = 3'd3,
        U_BRANCH = 3'd4
    } unit_e;

    typedef struct packed {
        logic [UNIT_W-1:0] src;
        logic [UNIT_W-1:0] dst;
        logic              last;
    } route_cmd_t;

    function automatic logic unit_legal(input logic [UNIT_W-1:0] u, input int n);
        return int'(u) < n;
    endfunction

endpackage

// File: rtl/rroute_fifo.sv
module rroute_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             wr_fire, rd_fire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    assign in_ready  = (count != FULL_CNT);
    assign out_valid = (count != '0);
    assign out_data  = mem[rptr];
    assign wr_fire   = in_valid && in_ready;
    assign rd_fire   = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_fire) wptr <= bump(wptr);
            if (rd_fire) rptr <= bump(rptr);
            case ({wr_fire, rd_fire})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wptr] <= in_data;
    end

    // R7 R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R7 R8
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !rd_fire) |=> (count == $past(count) + CNT_W'(1)));

    // R10
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !wr_fire) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/rroute_xbar.sv
module rroute_xbar
    import rroute_pkg::*;
#(
    parameter int N = 5,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  route_cmd_t          cmd,
    output logic                cmd_ready,
    input  logic [N-1:0]        src_valid,
    input  logic [N-1:0][W-1:0] src_data,
    output logic [N-1:0]        src_pop,
    input  logic [N-1:0]        dst_space,
    output logic [N-1:0]        dst_push,
    output logic [W-1:0]        dst_data,
    output logic                err
);
    logic         legal;
    logic         sel_valid;
    logic         sel_space;
    logic [W-1:0] sel_data;
    logic         fire;
    logic         err_q;

    assign legal = unit_legal(cmd.src, N) && unit_legal(cmd.dst, N);

    always_comb begin
        sel_valid = 1'b0;
        sel_space = 1'b0;
        sel_data  = '0;
        for (int i = 0; i < N; i++) begin
            if (cmd.src == UNIT_W'(i)) begin
                sel_valid = src_valid[i];
                sel_data  = src_data[i];
            end
            if (cmd.dst == UNIT_W'(i)) begin
                sel_space = dst_space[i];
            end
        end
    end

    assign cmd_ready = legal ? (sel_valid && sel_space) : 1'b1;
    assign fire      = cmd_valid && legal && sel_valid && sel_space;
    assign dst_data  = sel_data;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            dst_push[i] = fire && (cmd.dst == UNIT_W'(i));
            src_pop[i]  = fire && cmd.last && (cmd.src == UNIT_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= cmd_valid && !legal;
    end

    assign err = err_q;

    // R3
    one_push_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dst_push));

    // R4 R5
    pop_needs_push_chk: assert property (@(posedge clk) disable iff (rst)
        (src_pop != '0) |-> (dst_push != '0));

    // R9
    bad_cmd_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !legal) |=> err);

    // R9
    bad_cmd_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !legal) |-> (dst_push == '0 && src_pop == '0));

    // R6
    empty_src_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && legal && !sel_valid) |-> !cmd_ready);

endmodule

// File: rtl/rroute_net.sv
module rroute_net
    import rroute_pkg::*;
#(
    parameter int N_UNITS = NUNITS,
    parameter int DW      = DATA_W,
    parameter int DEPTH   = QDEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_UNITS-1:0]      res_valid,
    output logic [N_UNITS-1:0]      res_ready,
    input  logic [N_UNITS*DW-1:0]   res_data,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [UNIT_W-1:0]       cmd_src,
    input  logic [UNIT_W-1:0]       cmd_dst,
    input  logic                    cmd_last,
    output logic [N_UNITS-1:0]      opd_valid,
    input  logic [N_UNITS-1:0]      opd_ready,
    output logic [N_UNITS*DW-1:0]   opd_data,
    output logic                    route_err
);
    route_cmd_t                   cmd;
    logic [N_UNITS-1:0]           head_valid;
    logic [N_UNITS-1:0][DW-1:0]   head_data;
    logic [N_UNITS-1:0]           head_pop;
    logic [N_UNITS-1:0]           opq_space;
    logic [N_UNITS-1:0]           opq_push;
    logic [DW-1:0]                opq_wdata;
    logic                         cmd_legal;

    assign cmd       = '{src: cmd_src, dst: cmd_dst, last: cmd_last};
    assign cmd_legal = unit_legal(cmd_src, N_UNITS) && unit_legal(cmd_dst, N_UNITS);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        rroute_fifo #(.W(DW), .DEPTH(DEPTH)) u_resq (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (res_valid[u]),
            .in_ready  (res_ready[u]),
            .in_data   (res_data[u*DW +: DW]),
            .out_valid (head_valid[u]),
            .out_ready (head_pop[u]),
            .out_data  (head_data[u])
        );

        rroute_fifo #(.W(DW), .DEPTH(DEPTH)) u_opq (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (opq_push[u]),
            .in_ready  (opq_space[u]),
            .in_data   (opq_wdata),
            .out_valid (opd_valid[u]),
            .out_ready (opd_ready[u]),
            .out_data  (opd_data[u*DW +: DW])
        );

        // R7
        push_room_chk: assert property (@(posedge clk) disable iff (rst)
            opq_push[u] |-> opq_space[u]);

        // R3
        push_lands_chk: assert property (@(posedge clk) disable iff (rst)
            opq_push[u] |=> opd_valid[u]);
    end

    rroute_xbar #(.N(N_UNITS), .W(DW)) u_xbar (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_ready (cmd_ready),
        .src_valid (head_valid),
        .src_data  (head_data),
        .src_pop   (head_pop),
        .dst_space (opq_space),
        .dst_push  (opq_push),
        .dst_data  (opq_wdata),
        .err       (route_err)
    );

    // R6
    src_present_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_legal) |-> (head_valid != '0));

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        (route_err && !$past(cmd_valid)) |-> 1'b0);

endmodule

// File: tb/rroute_net_tb.sv
module rroute_net_tb;
    import rroute_pkg::*;

    localparam int N = NUNITS;
    localparam int W = DATA_W;

    logic             clk = 1'b0;
    logic             rst;
    logic [N-1:0]     res_valid;
    logic [N-1:0]     res_ready;
    logic [N*W-1:0]   res_data;
    logic             cmd_valid;
    logic             cmd_ready;
    logic [UNIT_W-1:0] cmd_src;
    logic [UNIT_W-1:0] cmd_dst;
    logic             cmd_last;
    logic [N-1:0]     opd_valid;
    logic [N-1:0]     opd_ready;
    logic [N*W-1:0]   opd_data;
    logic             route_err;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] srcq [N][$];
    logic [W-1:0] expq [N][$];

    always #10 clk = ~clk;

    rroute_net u_dut (
        .clk(clk), .rst(rst),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_last(cmd_last),
        .opd_valid(opd_valid), .opd_ready(opd_ready), .opd_data(opd_data),
        .route_err(route_err)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                if (opd_valid[i] && opd_ready[i]) begin
                    if (expq[i].size() == 0) begin
                        check(1'b0, "R10 unexpected operand", opd_data[i*W +: W], '0);
                    end else begin
                        logic [W-1:0] e;
                        e = expq[i].pop_front();
                        check(opd_data[i*W +: W] == e, "R3 R10 delivered value", opd_data[i*W +: W], e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R6 R7 watchdog expired", '0, 32'd1);
        summary();
    end

    task automatic push_result(input int u, input logic [W-1:0] d);
        @(posedge clk); #1;
        res_valid[u] = 1'b1;
        res_data[u*W +: W] = d;
        @(negedge clk);
        while (!res_ready[u]) @(negedge clk);
        srcq[u].push_back(d);
        @(posedge clk); #1;
        res_valid[u] = 1'b0;
    endtask

    task automatic route(input int s, input int d, input bit last, input bit exp_err);
        bit legal;
        legal = (s < N) && (d < N);
        @(posedge clk); #1;
        cmd_valid = 1'b1;
        cmd_src   = UNIT_W'(s);
        cmd_dst   = UNIT_W'(d);
        cmd_last  = last;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        if (legal) begin
            expq[d].push_back(srcq[s][0]);
            if (last) void'(srcq[s].pop_front());
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        check(route_err == exp_err, "R9 error flag after command", W'(route_err), W'(exp_err));
        if (legal) begin
            check(opd_valid[d] == 1'b1, "R3 operand valid one edge after accept", W'(opd_valid[d]), 32'd1);
        end else begin
            @(negedge clk);
            check(route_err == 1'b0, "R9 error flag lasts one cycle", W'(route_err), '0);
        end
    endtask

    initial begin
        rst       = 1'b1;
        res_valid = '0;
        res_data  = '0;
        cmd_valid = 1'b0;
        cmd_src   = '0;
        cmd_dst   = '0;
        cmd_last  = 1'b0;
        opd_ready = '1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(opd_valid == '0, "R1 operand queues empty", W'(opd_valid), '0);
        check(res_ready == '1, "R1 result queues ready", W'(res_ready), W'(5'h1f));
        check(route_err == 1'b0, "R1 error flag clear", W'(route_err), '0);

        // R3 basic ALU -> register
        push_result(0, 32'h0000_0011);
        route(0, 1, 1'b1, 1'b0);

        // R2 every pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                push_result(s, 32'hC0DE_0000 | (s << 8) | d);
                route(s, d, 1'b1, 1'b0);
            end
        end

        // R4 reuse from load/store, R5 release on last use
        push_result(2, 32'hA5A5_0001);
        route(2, 0, 1'b0, 1'b0);
        route(2, 3, 1'b0, 1'b0);
        route(2, 4, 1'b1, 1'b0);

        // R6 empty source stalls
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_src = 3'd2; cmd_dst = 3'd1; cmd_last = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(cmd_ready == 1'b0, "R5 R6 stall after source released", W'(cmd_ready), '0);
            check(opd_valid[1] == 1'b0, "R6 nothing delivered while stalled", W'(opd_valid[1]), '0);
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        push_result(2, 32'hA5A5_0002);
        route(2, 1, 1'b1, 1'b0);

        // R7 full destination queue (move unit)
        @(posedge clk); #1;
        opd_ready[3] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            push_result(0, 32'hF00D_0000 + k);
            route(0, 3, 1'b1, 1'b0);
        end
        push_result(0, 32'hF00D_0004);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_src = 3'd0; cmd_dst = 3'd3; cmd_last = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(cmd_ready == 1'b0, "R7 stall on full operand queue", W'(cmd_ready), '0);
            check(opd_data[3*W +: W] == 32'hF00D_0000, "R7 queue head unchanged", opd_data[3*W +: W], 32'hF00D_0000);
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        opd_ready[3] = 1'b1;
        route(0, 3, 1'b1, 1'b0);

        // R8 full result queue (branch unit), then R10 order
        for (int k = 0; k < 4; k++) push_result(4, 32'hBEEF_0000 + k);
        @(posedge clk); #1;
        res_valid[4] = 1'b1;
        res_data[4*W +: W] = 32'hDEAD_DEAD;
        @(negedge clk);
        check(res_ready[4] == 1'b0, "R8 result queue full", W'(res_ready[4]), '0);
        @(posedge clk); #1;
        res_valid[4] = 1'b0;
        for (int k = 0; k < 4; k++) route(4, 0, 1'b1, 1'b0);

        // R9 illegal commands
        push_result(0, 32'h1234_5678);
        route(6, 1, 1'b1, 1'b1);
        route(0, 7, 1'b1, 1'b1);
        route(5, 5, 1'b0, 1'b1);
        @(negedge clk);
        check(opd_valid == '0, "R9 illegal command delivers nothing", W'(opd_valid), '0);
        route(0, 1, 1'b1, 1'b0);

        // drain
        for (int t = 0; t < 50; t++) begin
            int left;
            left = 0;
            for (int i = 0; i < N; i++) left += expq[i].size();
            if (left == 0) break;
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) begin
            check(expq[i].size() == 0, "R10 all expected operands delivered", W'(expq[i].size()), '0);
        end
        summary();
    end

endmodule